// File: doc/BRIEF.md
# Memory-Mapped Flash Read Engine

This block lets a requester read serial flash as if it were ordinary memory. A read into a 64 MiB window becomes a flash read. The command, option, dummy and phase settings for that read are programmed once into configuration registers. The address sent to the flash joins the window offset with an upper-address field held in its own register. When that register's size code calls for it, the address is cut down to three bytes.

The engine has two modes. With caching off, every window read becomes a flash read of one 32-bit word. With caching on, a miss fetches a burst of programmable length into a small line cache. The requester is released as soon as the first word arrives, and later reads of the fetched words return one cycle after the request without touching the flash.

Software can flush the cache. After a flush, the engine accepts no window read until the control register has been read back once. The engine formats each fetch as a descriptor for a downstream serializer and takes the returned words back as a stream of valid beats.

Top module: `mmflash_read_engine`

## Requirements
- R1: After reset, `rd_ack` and `fl_start` are low and every configuration register reads back as zero.
- R2: With the burst-enable bit (bit 0 of the control register at index 0) clear, every window read starts a fetch with `fl_words` = 1. Repeating the same read fetches again. The data word is returned with `rd_ack` in the cycle after the beat arrives.
- R3: With burst enabled, a miss starts a fetch at the requested word. The fetch length is the smaller of the burst field + 1 and the number of words left to the end of the requested word's 128-byte line. The burst field sits at bits 12:8 of the control register and holds the number of words minus one.
- R4: A read that hits the cache raises `rd_ack` with the cached word one cycle after it is accepted, and `fl_start` stays low.
- R5: The words a burst delivered become hits. Words of the same line beyond the burst still miss, and their fetch fills the same line.
- R6: Writing 1 to bit 1 of the control register invalidates every cached word. That bit always reads back as 0.
- R7: After a flush write, window reads are not accepted (no `rd_ack`, no `fl_start`) until the control register (index 0) is read with `cfg_rd`.
- R8: `fl_addr` is {upper field (index 5, bits 3:0), window word address, 2'b00}. When the address phase is enabled (phase bit 2), `fl_addr_bytes` is 3 if the size code (index 5, bits 10:8) is 0, and the address is then masked to 24 bits. For any nonzero size code it is 4. With the address phase disabled, `fl_addr_bytes` is 0.
- R9: The descriptor passes the settings through unchanged. `fl_cmd` comes from index 1. `fl_opt` comes from index 2. `fl_cmd_en` comes from phase bits 1:0, `fl_opt_en` from phase bits 7:4 and `fl_width` from phase bits 23:16. `fl_dummy` is the index 3 value + 1 when phase bit 3 is set, and 0 otherwise.
- R10: The data-length enable bits (phase bits 11:8) are stored and read back but have no effect on `fl_words`.
- R11: The cache holds two lines and replaces them oldest-allocated first. A third line evicts the first.
- R12: `rd_ack` is a one-cycle pulse, and no new window read is accepted in the cycle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Window read request, held until `rd_ack` |
| rd_addr | input | 26 | Window byte address (low two bits ignored) |
| rd_ack | output | 1 | One-cycle pulse: `rd_data` is valid |
| rd_data | output | 32 | Read data |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_rd | input | 1 | Configuration register read strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| fl_start | output | 1 | One-cycle pulse starting a flash fetch |
| fl_cmd | output | 16 | Command bytes (main in 7:0, second in 15:8) |
| fl_cmd_en | output | 2 | Command byte enables |
| fl_addr | output | 32 | Flash byte address of the first word |
| fl_addr_bytes | output | 3 | Address bytes to send (0, 3 or 4) |
| fl_opt | output | 32 | Option data |
| fl_opt_en | output | 4 | Option byte enables |
| fl_dummy | output | 6 | Dummy cycles (0 = none) |
| fl_width | output | 8 | Bus width codes for command, address, option and data |
| fl_words | output | 6 | Number of 32-bit words to fetch |
| fl_rvalid | input | 1 | Returned word valid |
| fl_rdata | input | 32 | Returned word |

## Verification
The bench targets bursts that run into the end of a 128-byte line. A design that ignored the line end would fetch too many words and write cache words past the line. The bench reads words just past a short burst: a design that marked the whole line valid would return stale data as a hit. It fills a third line to check that the oldest line is evicted, fills after a flush, and issues window reads before the required control read-back, which a design that dropped the hold would accept. It also checks the three-byte address mask, the ignored data-length enables, and reads whose single-word fetch ends in the same cycle the acknowledge rises, where a design that re-accepted the held request would start a second fetch.

// File: rtl/mmflash_read_engine.sv
module mmflash_read_engine #(
  parameter int WIN_AW  = 26,
  parameter int UP_W    = 4,
  parameter int LINE_LG = 5,
  parameter int LINES   = 2,
  parameter int BLEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [WIN_AW-1:0] rd_addr,
  output logic              rd_ack,
  output logic [31:0]       rd_data,
  input  logic              cfg_we,
  input  logic              cfg_rd,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              fl_start,
  output logic [15:0]       fl_cmd,
  output logic [1:0]        fl_cmd_en,
  output logic [31:0]       fl_addr,
  output logic [2:0]        fl_addr_bytes,
  output logic [31:0]       fl_opt,
  output logic [3:0]        fl_opt_en,
  output logic [5:0]        fl_dummy,
  output logic [7:0]        fl_width,
  output logic [BLEN_W:0]   fl_words,
  input  logic              fl_rvalid,
  input  logic [31:0]       fl_rdata
);
  localparam int FW     = UP_W + WIN_AW - 2;
  localparam int TAG_W  = FW - LINE_LG;
  localparam int LINE_W = 1 << LINE_LG;
  localparam int EW     = (LINES > 1) ? $clog2(LINES) : 1;

  logic              burst_en, hold, busy, fill;
  logic [BLEN_W-1:0] blen_m1;
  logic [15:0]       cmd_r;
  logic [31:0]       opt_r;
  logic [4:0]        dmy_r;
  logic [23:0]       ph_r;
  logic [UP_W-1:0]   up_r;
  logic [2:0]        asz_r;

  logic [31:0]       mem [LINES][LINE_W];
  logic [LINE_W-1:0] wv  [LINES];
  logic [TAG_W-1:0]  tag [LINES];
  logic [LINES-1:0]  ev;
  logic [EW-1:0]     rr, ent, hit_idx, tm_idx;
  logic [LINE_LG-1:0] off;
  logic [BLEN_W:0]   beat, words_calc;
  logic              hit_any, tm_any, accept;

  logic [FW-1:0]      req_waddr;
  logic [TAG_W-1:0]   req_tag;
  logic [LINE_LG-1:0] req_off;
  logic [31:0]        req_baddr;

  assign req_waddr = {up_r, rd_addr[WIN_AW-1:2]};
  assign req_tag   = req_waddr[FW-1:LINE_LG];
  assign req_off   = req_waddr[LINE_LG-1:0];
  assign req_baddr = (asz_r == 3'd0) ? {8'h00, 24'({req_waddr, 2'b00})} : 32'({req_waddr, 2'b00});
  assign accept    = !busy && rd_req && !rd_ack && !hold;

  logic unused_ok;
  assign unused_ok = ^rd_addr[1:0];

  assign fl_cmd        = cmd_r;
  assign fl_cmd_en     = ph_r[1:0];
  assign fl_opt        = opt_r;
  assign fl_opt_en     = ph_r[7:4];
  assign fl_width      = ph_r[23:16];
  assign fl_dummy      = ph_r[3] ? ({1'b0, dmy_r} + 6'd1) : 6'd0;
  assign fl_addr_bytes = !ph_r[2] ? 3'd0 : (asz_r == 3'd0) ? 3'd3 : 3'd4;

  always_comb begin
    int room, blen;
    room = LINE_W - int'(req_off);
    blen = int'(blen_m1) + 1;
    words_calc = burst_en ? (BLEN_W+1)'((room < blen) ? room : blen) : (BLEN_W+1)'(1);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    tm_any  = 1'b0;
    tm_idx  = '0;
    for (int i = 0; i < LINES; i++) begin
      if (ev[i] && tag[i] == req_tag) begin
        tm_any = 1'b1;
        tm_idx = EW'(i);
        if (wv[i][req_off]) begin
          hit_any = 1'b1;
          hit_idx = EW'(i);
        end
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = 32'(burst_en) | (32'(blen_m1) << 8);
      3'd1:    cfg_rdata = {16'h0000, cmd_r};
      3'd2:    cfg_rdata = opt_r;
      3'd3:    cfg_rdata = {27'd0, dmy_r};
      3'd4:    cfg_rdata = {8'h00, ph_r};
      3'd5:    cfg_rdata = 32'(up_r) | (32'(asz_r) << 8);
      default: cfg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (busy && fl_rvalid && fill) mem[ent][off] <= fl_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_en <= 1'b0; blen_m1 <= '0; cmd_r <= '0; opt_r <= '0; dmy_r <= '0;
      ph_r <= '0; up_r <= '0; asz_r <= '0; hold <= 1'b0;
      rd_ack <= 1'b0; rd_data <= '0; fl_start <= 1'b0; busy <= 1'b0; fill <= 1'b0;
      ent <= '0; off <= '0; beat <= '0; fl_words <= '0; fl_addr <= '0; rr <= '0; ev <= '0;
      for (int i = 0; i < LINES; i++) begin
        wv[i]  <= '0;
        tag[i] <= '0;
      end
    end else begin
      rd_ack   <= 1'b0;
      fl_start <= 1'b0;
      if (accept) begin
        if (burst_en && hit_any) begin
          rd_ack  <= 1'b1;
          rd_data <= mem[hit_idx][req_off];
        end else begin
          busy     <= 1'b1;
          fl_start <= 1'b1;
          fl_addr  <= req_baddr;
          fl_words <= words_calc;
          beat     <= '0;
          off      <= req_off;
          fill     <= burst_en;
          if (burst_en) begin
            if (tm_any) begin
              ent <= tm_idx;
            end else begin
              ent      <= rr;
              tag[rr]  <= req_tag;
              ev[rr]   <= 1'b1;
              wv[rr]   <= '0;
              rr       <= (rr == EW'(LINES-1)) ? '0 : rr + 1'b1;
            end
          end
        end
      end else if (busy && fl_rvalid) begin
        if (fill) wv[ent][off] <= 1'b1;
        if (beat == '0) begin
          rd_ack  <= 1'b1;
          rd_data <= fl_rdata;
        end
        off  <= off + 1'b1;
        beat <= beat + 1'b1;
        if (beat == fl_words - 1'b1) busy <= 1'b0;
      end
      if (cfg_rd && cfg_addr == 3'd0) hold <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin
            burst_en <= cfg_wdata[0];
            blen_m1  <= cfg_wdata[8 +: BLEN_W];
            if (cfg_wdata[1]) begin
              hold <= 1'b1;
              ev   <= '0;
              for (int i = 0; i < LINES; i++) wv[i] <= '0;
            end
          end
          3'd1: cmd_r <= cfg_wdata[15:0];
          3'd2: opt_r <= cfg_wdata;
          3'd3: dmy_r <= cfg_wdata[4:0];
          3'd4: ph_r  <= cfg_wdata[23:0];
          3'd5: begin
            up_r  <= cfg_wdata[UP_W-1:0];
            asz_r <= cfg_wdata[10:8];
          end
          default: ;
        endcase
      end
    end
  end

  // R12
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack);

  // R4
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && burst_en && hit_any) |=> (rd_ack && !fl_start && !busy));

  // R7
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !busy) |=> !fl_start);

  // R2
  direct_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_start && !fill) |-> fl_words == (BLEN_W+1)'(1));

  // R3
  words_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> (fl_words != '0 && int'(fl_words) + int'(off) <= LINE_W));

  // R5
  fetch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fl_rvalid && beat == fl_words - 1'b1) |=> !busy);
endmodule

// File: tb/mmflash_read_engine_tb.sv
module mmflash_read_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_req = 1'b0, rd_ack;
  logic [25:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic cfg_we = 1'b0, cfg_rd = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic fl_start;
  logic [15:0] fl_cmd;
  logic [1:0] fl_cmd_en;
  logic [31:0] fl_addr, fl_opt;
  logic [2:0] fl_addr_bytes;
  logic [3:0] fl_opt_en;
  logic [5:0] fl_dummy, fl_words;
  logic [7:0] fl_width;
  logic fl_rvalid = 1'b0;
  logic [31:0] fl_rdata = '0;

  always #4 clk = ~clk;

  mmflash_read_engine dut_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .cfg_we(cfg_we), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fl_start(fl_start), .fl_cmd(fl_cmd),
    .fl_cmd_en(fl_cmd_en), .fl_addr(fl_addr), .fl_addr_bytes(fl_addr_bytes),
    .fl_opt(fl_opt), .fl_opt_en(fl_opt_en), .fl_dummy(fl_dummy), .fl_width(fl_width),
    .fl_words(fl_words), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state
  bit m_burst = 0;
  int m_blen = 1, m_up = 0, m_asz = 0;
  bit m_aen = 0;
  int q_tags[$];
  bit cached[int];

  function automatic logic [31:0] fdata(int w);
    return (32'(w) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    #1 d = cfg_rdata;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic model_flush();
    q_tags.delete();
    cached.delete();
  endtask

  task automatic model_fill(int w, int n);
    int line = w >> 5;
    int found = 0;
    foreach (q_tags[i]) if (q_tags[i] == line) found = 1;
    if (!found) begin
      if (q_tags.size() == 2) begin
        int old = q_tags.pop_front();
        int kill[$];
        foreach (cached[k]) if ((k >> 5) == old) kill.push_back(k);
        foreach (kill[j]) cached.delete(kill[j]);
      end
      q_tags.push_back(line);
    end
    for (int i = 0; i < n; i++) cached[w + i] = 1'b1;
  endtask

  task automatic do_read(logic [25:0] a, string req);
    int w = (m_up << 24) | int'(a >> 2);
    bit hit = m_burst && cached.exists(w);
    int room = 32 - (w & 31);
    int n = !m_burst ? 1 : (room < m_blen ? room : m_blen);
    logic [31:0] ea = {w[29:0], 2'b00};
    logic [2:0] eb = !m_aen ? 3'd0 : (m_asz == 0 ? 3'd3 : 3'd4);
    if (m_asz == 0) ea = ea & 32'h00FF_FFFF;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    if (hit) begin
      chk(rd_ack === 1'b1, req, "hit ack", 32'(rd_ack), 1);
      chk(rd_data === fdata(w), req, "hit data", rd_data, fdata(w));
      chk(fl_start === 1'b0, req, "hit no fetch", 32'(fl_start), 0);
      @(negedge clk);
      rd_req = 1'b0;
      @(posedge clk); #1;
      chk(rd_ack === 1'b0, "R12", "ack pulse", 32'(rd_ack), 0);
      return;
    end
    chk(fl_start === 1'b1, req, "miss fetch", 32'(fl_start), 1);
    chk(rd_ack === 1'b0, req, "miss no early ack", 32'(rd_ack), 0);
    chk(fl_words === 6'(n), req, "fetch words", 32'(fl_words), 32'(n));
    chk(fl_addr === ea, "R8", "fetch address", fl_addr, ea);
    chk(fl_addr_bytes === eb, "R8", "address bytes", 32'(fl_addr_bytes), 32'(eb));
    if (m_burst) model_fill(w, n);
    @(negedge clk);
    @(posedge clk); #1;
    chk(rd_ack === 1'b0 && fl_start === 1'b0, req, "wait cycle quiet", 32'({rd_ack, fl_start}), 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fl_rvalid = 1'b1; fl_rdata = fdata(w + i);
      if (i > 0) rd_req = 1'b0;
      @(posedge clk); #1;
      if (i == 0) begin
        chk(rd_ack === 1'b1, req, "ack on first beat", 32'(rd_ack), 1);
        chk(rd_data === fdata(w), req, "miss data", rd_data, fdata(w));
      end else begin
        chk(rd_ack === 1'b0, "R12", "no ack on later beat", 32'(rd_ack), 0);
      end
    end
    @(negedge clk);
    fl_rvalid = 1'b0; rd_req = 1'b0;
    @(posedge clk); #1;
    chk(rd_ack === 1'b0 && fl_start === 1'b0, "R12", "no re-accept", 32'({rd_ack, fl_start}), 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    #1;
    chk(rd_ack === 1'b0 && fl_start === 1'b0, "R1", "reset outputs", 32'({rd_ack, fl_start}), 0);
    rst_n = 1'b1;
    for (int r = 0; r < 6; r++) begin
      cfg_read(3'(r), d);
      chk(d === 32'd0, "R1", "reset register", d, 0);
    end

    cfg_write(3'd1, 32'h0000_00EB);
    cfg_write(3'd3, 32'd7);
    cfg_write(3'd4, 32'h005A_0F0D);
    cfg_write(3'd5, 32'h0000_0105);
    m_up = 5; m_asz = 1; m_aen = 1;
    @(negedge clk); #1;
    chk(fl_cmd === 16'h00EB, "R9", "command", 32'(fl_cmd), 32'h00EB);
    chk(fl_cmd_en === 2'd1, "R9", "command enables", 32'(fl_cmd_en), 1);
    chk(fl_dummy === 6'd8, "R9", "dummy cycles", 32'(fl_dummy), 8);
    chk(fl_width === 8'h5A, "R9", "widths", 32'(fl_width), 32'h5A);
    cfg_read(3'd4, d);
    chk(d === 32'h005A_0F0D, "R10", "data enables stored", d, 32'h005A_0F0D);

    do_read(26'h100, "R2");
    do_read(26'h100, "R2");

    cfg_write(3'd0, 32'h0000_0701);
    m_burst = 1; m_blen = 8;
    do_read(26'h200, "R3");
    do_read(26'h204, "R4");
    do_read(26'h21C, "R4");
    do_read(26'h220, "R5");
    do_read(26'h224, "R5");
    do_read(26'h2F0, "R3");
    do_read(26'h2FC, "R5");
    do_read(26'h400, "R11");
    do_read(26'h204, "R11");
    do_read(26'h2F4, "R11");

    cfg_write(3'd0, 32'h0000_0703);
    model_flush();
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 26'h400;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(rd_ack === 1'b0 && fl_start === 1'b0, "R7", "held after flush", 32'({rd_ack, fl_start}), 0);
    end
    @(negedge clk);
    rd_req = 1'b0;
    cfg_read(3'd0, d);
    chk(d === 32'h0000_0701, "R6", "flush bit reads zero", d, 32'h0000_0701);
    do_read(26'h400, "R6");
    do_read(26'h404, "R6");

    cfg_write(3'd5, 32'h0000_0005);
    m_asz = 0;
    do_read(26'h1FF_FFFC, "R8");

    cfg_write(3'd2, 32'hCAFE_F00D);
    cfg_write(3'd4, 32'h00A5_00F2);
    m_aen = 0;
    @(negedge clk); #1;
    chk(fl_opt === 32'hCAFE_F00D, "R9", "option data", fl_opt, 32'hCAFE_F00D);
    chk(fl_opt_en === 4'hF, "R9", "option enables", 32'(fl_opt_en), 32'hF);
    chk(fl_cmd_en === 2'd2, "R9", "second command enable", 32'(fl_cmd_en), 2);
    chk(fl_dummy === 6'd0, "R9", "dummy disabled", 32'(fl_dummy), 0);
    do_read(26'h800, "R10");

    cfg_write(3'd0, 32'h0000_1F01);
    m_blen = 32;
    do_read(26'hC00, "R3");
    do_read(26'hC7C, "R5");
    cfg_write(3'd0, 32'h0000_0001);
    m_blen = 1;
    do_read(26'hE08, "R3");
    do_read(26'hE08, "R4");
    do_read(26'hE0C, "R5");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule